// File: doc/BRIEF.md
# Strided 3D DMA address generator

This block produces the memory-side address stream for slave DMA descriptors whose buffer is not contiguous. A buffer is a run of frames. Each frame holds a fixed number of chunks, and each chunk is a run of contiguous bytes. A programmable gap is skipped after every chunk. After the last chunk of a frame, a separate gap is skipped in its place. The number of frames is never programmed. The block derives it from the total length and rejects any length that does not fit the pattern.

Software loads descriptors into a small in-order queue. The block pops one descriptor at a time. It waits for a peripheral sync event and then issues one beat per cycle. Each beat carries a memory address, the peripheral FIFO address (fixed for the whole descriptor) and a beat-size code. A descriptor-level field selects how much one sync event releases: one chunk or one whole frame. A one-cycle done pulse closes each descriptor. A one-cycle error pulse closes a malformed descriptor, and no beats are issued for it.

Top module: `stride_dma_agu`

## Requirements
- R1: Within a chunk, consecutive beats advance the memory address by the beat size. The first beat of a descriptor uses the base address.
- R2: After the last beat of a chunk that is not the last chunk of its frame, the next beat address is the last beat address plus the beat size plus the chunk gap.
- R3: After the last beat of the last chunk of a frame, the next beat address is the last beat address plus the beat size plus the frame gap. The chunk gap is not added there.
- R4: With the frame-sync field at 0, each sync event releases exactly one chunk. With it at 1, each sync event releases exactly one whole frame.
- R5: The descriptor runs for total length / (chunk bytes × chunks per frame) frames. The total beat count is that frame count × chunks per frame × chunk bytes / beat size.
- R6: The beat-size code selects 1, 2, 4 or 8 bytes for codes 0, 1, 2 and 3. The code is presented on `beat_code` with every beat.
- R7: A descriptor is rejected with a one-cycle `xfer_error` pulse and no beats when any of these holds: total length is 0, chunk bytes is 0, chunks per frame is 0, chunk bytes is not a multiple of the beat size, or total length is not a multiple of chunk bytes × chunks per frame.
- R8: Sync events that arrive while a descriptor is active are held in a pending count. The count saturates at 4, and each release consumes one. Events beyond the saturation point are dropped.
- R9: `beat_fifo_addr` equals the descriptor's FIFO address on every beat of that descriptor.
- R10: `xfer_done` is a one-cycle pulse in the cycle after the last beat. The block then takes the next queued descriptor.
- R11: Descriptors run strictly in load order, one after another. `queue_full` is high when 4 descriptors wait. A load while it is high is ignored and never produces beats.
- R12: A de-interlaced transfer of line width L can be described as two descriptors. Both use chunk bytes = L, one chunk per frame and frame gap = L. One starts at line 0 and the other at line 1, so together they visit the even lines and then the odd lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_push | input | 1 | Load a descriptor built from the cfg_* fields |
| cfg_base | input | 32 | Memory start address |
| cfg_fifo_addr | input | 32 | Peripheral FIFO address |
| cfg_chunk_bytes | input | 16 | Bytes per chunk |
| cfg_chunks_per_frame | input | 8 | Chunks per frame |
| cfg_chunk_gap | input | 16 | Bytes skipped after a non-final chunk |
| cfg_frame_gap | input | 16 | Bytes skipped after a frame's last chunk |
| cfg_total_len | input | 16 | Total bytes to move |
| cfg_frame_sync | input | 1 | 0: one sync releases a chunk; 1: a frame |
| cfg_beat_code | input | 2 | Beat size code (1 << code bytes) |
| queue_full | output | 1 | Descriptor queue holds its maximum |
| sync_in | input | 1 | Peripheral sync event, one per cycle high |
| beat_valid | output | 1 | A beat is issued this cycle |
| beat_addr | output | 32 | Memory address of the beat |
| beat_fifo_addr | output | 32 | Peripheral FIFO address of the beat |
| beat_code | output | 2 | Beat size code of the beat |
| xfer_done | output | 1 | Descriptor finished (one cycle) |
| xfer_error | output | 1 | Descriptor rejected (one cycle) |

## Verification
The in-line checks assume that beats are always accepted, because the block has no back-pressure. They also assume a sync event is a level sampled each clock, not an edge, and that descriptor fields stay valid during the cycle `cfg_push` is high. The bench keeps within these limits by driving every input shortly after the falling edge. It holds each field for exactly the load cycle and never pushes while its own model expects the queue to be full, except in the one case that tests the ignored load. Sync is either held high for free-running transfers or pulsed for single cycles to count releases exactly.

// File: rtl/sdma_stride_pkg.sv
package sdma_stride_pkg;

    parameter int ADDR_W = 32;
    parameter int LEN_W  = 16;
    parameter int CPF_W  = 8;
    localparam int FB_W  = LEN_W + CPF_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] fifo_addr;
        logic [LEN_W-1:0]  chunk_bytes;
        logic [CPF_W-1:0]  chunks_per_frame;
        logic [LEN_W-1:0]  chunk_gap;
        logic [LEN_W-1:0]  frame_gap;
        logic [LEN_W-1:0]  total_len;
        logic              frame_sync;
        logic [1:0]        beat_code;
    } stride_desc_t;

    typedef enum logic [2:0] {
        WS_IDLE  = 3'd0,
        WS_CHECK = 3'd1,
        WS_WAIT  = 3'd2,
        WS_RUN   = 3'd3,
        WS_DONE  = 3'd4,
        WS_ERR   = 3'd5
    } walk_state_t;

    function automatic logic [3:0] beat_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    function automatic logic chunk_misaligned(input logic [LEN_W-1:0] chunk,
                                              input logic [1:0] code);
        logic [LEN_W-1:0] mask;
        mask = LEN_W'(beat_bytes(code)) - LEN_W'(1);
        return (chunk & mask) != '0;
    endfunction

endpackage

// File: rtl/sdma_desc_queue.sv
module sdma_desc_queue
    import sdma_stride_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  stride_desc_t push_desc,
    input  logic         pop,
    output stride_desc_t head,
    output logic         not_empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    stride_desc_t   slots [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  count;
    logic           do_push, do_pop;

    assign full      = (count == CW'(DEPTH));
    assign not_empty = (count != '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;
    assign head      = slots[rd_ptr];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                slots[wr_ptr] <= push_desc;
                wr_ptr        <= wrap_inc(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= wrap_inc(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R11
    q_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R11
    q_ignore_full_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/sdma_sync_pending.sv
module sdma_sync_pending #(
    parameter int MAX_PENDING = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic sync_in,
    input  logic take,
    output logic avail
);
    localparam int CW = $clog2(MAX_PENDING + 1);

    logic [CW-1:0] count;

    assign avail = (count != '0);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            count <= '0;
        end else begin
            case ({sync_in, take && avail})
                2'b10:   count <= (count == CW'(MAX_PENDING)) ? count : count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R8
    sync_sat_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(MAX_PENDING));

    // R8
    sync_take_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> avail);

endmodule

// File: rtl/sdma_stride_walker.sv
module sdma_stride_walker
    import sdma_stride_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  stride_desc_t      head,
    input  logic              head_valid,
    input  logic              sync_avail,
    output logic              pop,
    output logic              sync_take,
    output logic              active,
    output logic              beat_valid,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [ADDR_W-1:0] beat_fifo_addr,
    output logic [1:0]        beat_code,
    output logic              done,
    output logic              error
);
    walk_state_t       st;
    stride_desc_t      d;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  off;
    logic [CPF_W-1:0]  chunk_idx;
    logic [LEN_W-1:0]  frames_left;
    logic [LEN_W-1:0]  frame_cnt;
    logic [FB_W-1:0]   rem;
    logic [FB_W-1:0]   fbytes;

    logic [3:0]        bb;
    logic              chunk_end, frame_end, last_beat, release_end, bad_shape;

    assign bb          = beat_bytes(d.beat_code);
    assign chunk_end   = ({1'b0, off} + (LEN_W+1)'(bb)) == {1'b0, d.chunk_bytes};
    assign frame_end   = chunk_end && (chunk_idx == d.chunks_per_frame - CPF_W'(1));
    assign last_beat   = frame_end && (frames_left == LEN_W'(1));
    assign release_end = d.frame_sync ? frame_end : chunk_end;
    assign bad_shape   = (d.total_len == '0) || (d.chunk_bytes == '0) ||
                         (d.chunks_per_frame == '0) ||
                         chunk_misaligned(d.chunk_bytes, d.beat_code);

    assign pop            = (st == WS_IDLE) && head_valid;
    assign sync_take      = (st == WS_WAIT) && sync_avail;
    assign active         = (st != WS_IDLE);
    assign beat_valid     = (st == WS_RUN);
    assign beat_addr      = addr;
    assign beat_fifo_addr = d.fifo_addr;
    assign beat_code      = d.beat_code;
    assign done           = (st == WS_DONE);
    assign error          = (st == WS_ERR);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= WS_IDLE;
            d           <= '0;
            addr        <= '0;
            off         <= '0;
            chunk_idx   <= '0;
            frames_left <= '0;
            frame_cnt   <= '0;
            rem         <= '0;
            fbytes      <= '0;
        end else begin
            case (st)
                WS_IDLE: begin
                    if (head_valid) begin
                        d         <= head;
                        rem       <= FB_W'(head.total_len);
                        fbytes    <= FB_W'(head.chunk_bytes) * FB_W'(head.chunks_per_frame);
                        frame_cnt <= '0;
                        st        <= WS_CHECK;
                    end
                end
                WS_CHECK: begin
                    if (bad_shape || (rem < fbytes)) begin
                        st <= WS_ERR;
                    end else if (rem == fbytes) begin
                        frames_left <= frame_cnt + LEN_W'(1);
                        addr        <= d.base;
                        off         <= '0;
                        chunk_idx   <= '0;
                        st          <= WS_WAIT;
                    end else begin
                        rem       <= rem - fbytes;
                        frame_cnt <= frame_cnt + LEN_W'(1);
                    end
                end
                WS_WAIT: begin
                    if (sync_avail) st <= WS_RUN;
                end
                WS_RUN: begin
                    if (chunk_end) begin
                        off <= '0;
                        if (frame_end) begin
                            chunk_idx   <= '0;
                            addr        <= addr + ADDR_W'(bb) + ADDR_W'(d.frame_gap);
                            frames_left <= frames_left - LEN_W'(1);
                        end else begin
                            chunk_idx <= chunk_idx + CPF_W'(1);
                            addr      <= addr + ADDR_W'(bb) + ADDR_W'(d.chunk_gap);
                        end
                        if (last_beat)        st <= WS_DONE;
                        else if (release_end) st <= WS_WAIT;
                    end else begin
                        off  <= off + LEN_W'(bb);
                        addr <= addr + ADDR_W'(bb);
                    end
                end
                default: st <= WS_IDLE;
            endcase
        end
    end

    // R1
    in_chunk_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(beat_valid && !chunk_end) && beat_valid)
        |-> (beat_addr == $past(beat_addr) + ADDR_W'($past(bb))));

    // R2
    chunk_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(beat_valid && chunk_end && !frame_end) && beat_valid)
        |-> (beat_addr == $past(beat_addr) + ADDR_W'($past(bb)) + ADDR_W'($past(d.chunk_gap))));

    // R9
    fifo_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(beat_valid) && beat_valid) |-> $stable(beat_fifo_addr));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(beat_valid));

    // R7
    err_from_check_chk: assert property (@(posedge clk) disable iff (rst)
        error |-> ($past(st) == WS_CHECK));

endmodule

// File: rtl/stride_dma_agu.sv
module stride_dma_agu
    import sdma_stride_pkg::*;
#(
    parameter int QUEUE_DEPTH = 4,
    parameter int SYNC_MAX    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_push,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_fifo_addr,
    input  logic [LEN_W-1:0]  cfg_chunk_bytes,
    input  logic [CPF_W-1:0]  cfg_chunks_per_frame,
    input  logic [LEN_W-1:0]  cfg_chunk_gap,
    input  logic [LEN_W-1:0]  cfg_frame_gap,
    input  logic [LEN_W-1:0]  cfg_total_len,
    input  logic              cfg_frame_sync,
    input  logic [1:0]        cfg_beat_code,
    output logic              queue_full,
    input  logic              sync_in,
    output logic              beat_valid,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [ADDR_W-1:0] beat_fifo_addr,
    output logic [1:0]        beat_code,
    output logic              xfer_done,
    output logic              xfer_error
);
    stride_desc_t in_desc, head;
    logic         head_valid, pop, sync_take, sync_avail, active;

    always_comb begin
        in_desc.base             = cfg_base;
        in_desc.fifo_addr        = cfg_fifo_addr;
        in_desc.chunk_bytes      = cfg_chunk_bytes;
        in_desc.chunks_per_frame = cfg_chunks_per_frame;
        in_desc.chunk_gap        = cfg_chunk_gap;
        in_desc.frame_gap        = cfg_frame_gap;
        in_desc.total_len        = cfg_total_len;
        in_desc.frame_sync       = cfg_frame_sync;
        in_desc.beat_code        = cfg_beat_code;
    end

    sdma_desc_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (cfg_push),
        .push_desc (in_desc),
        .pop       (pop),
        .head      (head),
        .not_empty (head_valid),
        .full      (queue_full)
    );

    sdma_sync_pending #(.MAX_PENDING(SYNC_MAX)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .enable  (active),
        .sync_in (sync_in),
        .take    (sync_take),
        .avail   (sync_avail)
    );

    sdma_stride_walker u_walker (
        .clk            (clk),
        .rst            (rst),
        .head           (head),
        .head_valid     (head_valid),
        .sync_avail     (sync_avail),
        .pop            (pop),
        .sync_take      (sync_take),
        .active         (active),
        .beat_valid     (beat_valid),
        .beat_addr      (beat_addr),
        .beat_fifo_addr (beat_fifo_addr),
        .beat_code      (beat_code),
        .done           (xfer_done),
        .error          (xfer_error)
    );

    // R7
    done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(xfer_done && xfer_error));

endmodule

// File: tb/test_stride_dma_agu.sv
module test_stride_dma_agu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_push = 1'b0;
    logic [31:0] cfg_base = '0, cfg_fifo_addr = '0;
    logic [15:0] cfg_chunk_bytes = '0, cfg_chunk_gap = '0, cfg_frame_gap = '0, cfg_total_len = '0;
    logic [7:0]  cfg_chunks_per_frame = '0;
    logic        cfg_frame_sync = 1'b0;
    logic [1:0]  cfg_beat_code = '0;
    logic        queue_full, beat_valid, xfer_done, xfer_error;
    logic [31:0] beat_addr, beat_fifo_addr;
    logic [1:0]  beat_code;
    logic        auto_sync = 1'b0, sync_man = 1'b0, sync_in;

    assign sync_in = auto_sync | sync_man;

    always #(CLK_PERIOD/2) clk = ~clk;

    stride_dma_agu i_stride_dma_agu (
        .clk(clk), .rst(rst), .cfg_push(cfg_push), .cfg_base(cfg_base),
        .cfg_fifo_addr(cfg_fifo_addr), .cfg_chunk_bytes(cfg_chunk_bytes),
        .cfg_chunks_per_frame(cfg_chunks_per_frame), .cfg_chunk_gap(cfg_chunk_gap),
        .cfg_frame_gap(cfg_frame_gap), .cfg_total_len(cfg_total_len),
        .cfg_frame_sync(cfg_frame_sync), .cfg_beat_code(cfg_beat_code),
        .queue_full(queue_full), .sync_in(sync_in), .beat_valid(beat_valid),
        .beat_addr(beat_addr), .beat_fifo_addr(beat_fifo_addr), .beat_code(beat_code),
        .xfer_done(xfer_done), .xfer_error(xfer_error)
    );

    int checks = 0, failures = 0;
    int beats_seen = 0, done_cnt = 0, err_cnt = 0;
    logic [31:0] exp_addr[$];
    logic [31:0] exp_fifo[$];
    logic [1:0]  exp_code[$];
    bit          exp_last[$];
    bit          prev_last = 0, prev_done = 0;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: samples on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            bit this_last;
            this_last = 0;
            if (xfer_done) begin
                done_cnt++;
                check("R10 done follows last beat", prev_last, 1);
                check("R10 done one cycle", prev_done, 0);
            end
            if (xfer_error) err_cnt++;
            if (beat_valid) begin
                beats_seen++;
                if (exp_addr.size() == 0) begin
                    check("R11/R7 unexpected beat", beat_addr, 32'hFFFF_FFFF);
                end else begin
                    check("R1-R3 beat address", beat_addr, exp_addr.pop_front());
                    check("R9 fifo address", beat_fifo_addr, exp_fifo.pop_front());
                    check("R6 beat code", beat_code, exp_code.pop_front());
                    this_last = exp_last.pop_front();
                end
            end
            prev_last = this_last;
            prev_done = xfer_done;
        end
    end

    // Driver: loads a descriptor and, when it is expected to run, pushes its beats
    task automatic push_desc(input logic [31:0] base, input logic [31:0] fifo,
                             input int chunk, input int cpf, input int cgap,
                             input int fgap, input int len, input bit fs,
                             input int code, input bit runs);
        @(negedge clk); #1;
        cfg_base = base; cfg_fifo_addr = fifo; cfg_chunk_bytes = 16'(chunk);
        cfg_chunks_per_frame = 8'(cpf); cfg_chunk_gap = 16'(cgap);
        cfg_frame_gap = 16'(fgap); cfg_total_len = 16'(len);
        cfg_frame_sync = fs; cfg_beat_code = 2'(code); cfg_push = 1'b1;
        @(negedge clk); #1;
        cfg_push = 1'b0;
        if (runs) begin
            int bsz, frames, bpc;
            logic [31:0] a;
            bsz = 1 << code;
            frames = len / (chunk * cpf);
            bpc = chunk / bsz;
            a = base;
            for (int f = 0; f < frames; f++)
                for (int c = 0; c < cpf; c++) begin
                    for (int b = 0; b < bpc; b++) begin
                        exp_addr.push_back(a);
                        exp_fifo.push_back(fifo);
                        exp_code.push_back(2'(code));
                        exp_last.push_back((f == frames-1) && (c == cpf-1) && (b == bpc-1));
                        if (b < bpc-1) a = a + 32'(bsz);
                    end
                    a = a + 32'(bsz) + 32'((c == cpf-1) ? fgap : cgap);
                end
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_sync();
        @(negedge clk); #1 sync_man = 1'b1;
        @(negedge clk); #1 sync_man = 1'b0;
    endtask

    task automatic wait_done(input int target);
        int t;
        t = 0;
        while (done_cnt < target && t < 5000) begin
            @(negedge clk);
            t++;
        end
        #1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int b0;
        cycles(4);
        rst = 1'b0;
        cycles(1);
        check("R10 reset beat_valid", beat_valid, 0);
        check("R10 reset done", xfer_done, 0);
        check("R7 reset error", xfer_error, 0);
        check("R11 reset queue_full", queue_full, 0);

        // R1 R2 R3 R5 R9: chunk pattern with 4-byte beats, free-running sync
        auto_sync = 1'b1;
        push_desc(32'h100, 32'hA000, 8, 3, 4, 16, 48, 0, 2, 1);
        wait_done(1);
        check("R5 frame count done", done_cnt, 1);
        check("R5 all beats issued", exp_addr.size(), 0);

        // R6: 1-byte beats, frame sync, two chunks per frame
        push_desc(32'h2003, 32'hB000, 3, 2, 5, 7, 12, 1, 0, 1);
        // R6: 8-byte beats
        push_desc(32'h4000, 32'hC000, 16, 1, 0, 8, 32, 0, 3, 1);
        wait_done(3);
        check("R6 sizes done", done_cnt, 3);
        check("R6 beats drained", exp_addr.size(), 0);

        // R12: de-interlace, line width 16, 4 lines per field
        push_desc(32'h1000, 32'hD000, 16, 1, 0, 16, 64, 0, 2, 1);
        push_desc(32'h1010, 32'hD000, 16, 1, 0, 16, 64, 0, 2, 1);
        wait_done(5);
        check("R12 both fields done", done_cnt, 5);
        check("R12 beats drained", exp_addr.size(), 0);

        // R7: malformed descriptors give errors and no beats
        b0 = beats_seen;
        push_desc(32'h0, 32'h0, 4, 2, 0, 0, 0, 0, 0, 0);
        push_desc(32'h0, 32'h0, 4, 2, 0, 0, 20, 0, 0, 0);
        push_desc(32'h0, 32'h0, 6, 1, 0, 0, 12, 0, 2, 0);
        push_desc(32'h0, 32'h0, 4, 0, 0, 0, 8, 0, 0, 0);
        push_desc(32'h0, 32'h0, 0, 2, 0, 0, 8, 0, 0, 0);
        cycles(40);
        check("R7 error pulses", err_cnt, 5);
        check("R7 no beats", beats_seen - b0, 0);
        check("R7 no done", done_cnt, 5);

        // R4: chunk granularity, one sync gives one chunk
        auto_sync = 1'b0;
        push_desc(32'h3000, 32'hE000, 4, 3, 2, 9, 24, 0, 0, 1);
        cycles(10);
        b0 = beats_seen;
        pulse_sync();
        cycles(30);
        check("R4 chunk per sync", beats_seen - b0, 4);
        auto_sync = 1'b1;
        wait_done(6);
        auto_sync = 1'b0;
        push_desc(32'h3800, 32'hE000, 4, 3, 2, 9, 24, 1, 0, 1);
        cycles(10);
        b0 = beats_seen;
        pulse_sync();
        cycles(40);
        check("R4 frame per sync", beats_seen - b0, 12);
        auto_sync = 1'b1;
        wait_done(7);
        check("R4 runs finish", done_cnt, 7);

        // R8: pending syncs saturate at 4
        auto_sync = 1'b0;
        push_desc(32'h5000, 32'hF000, 8, 8, 1, 3, 64, 0, 0, 1);
        cycles(10);
        b0 = beats_seen;
        @(negedge clk); #1 sync_man = 1'b1;
        @(negedge clk); #1 sync_man = 1'b0;
        cycles(2);
        sync_man = 1'b1;
        cycles(6);
        sync_man = 1'b0;
        cycles(80);
        check("R8 saturated release", beats_seen - b0, 40);
        check("R8 not yet done", done_cnt, 7);
        auto_sync = 1'b1;
        wait_done(8);
        check("R8 completes", done_cnt, 8);

        // R11: in-order queue, load ignored when full
        auto_sync = 1'b0;
        push_desc(32'h6000, 32'h9000, 2, 2, 0, 0, 8, 0, 1, 1);
        cycles(5);
        push_desc(32'h6100, 32'h9100, 2, 1, 0, 4, 4, 0, 0, 1);
        push_desc(32'h6200, 32'h9200, 4, 1, 0, 0, 4, 0, 2, 1);
        push_desc(32'h6300, 32'h9300, 2, 2, 6, 0, 4, 1, 0, 1);
        push_desc(32'h6400, 32'h9400, 1, 1, 0, 1, 3, 0, 0, 1);
        check("R11 queue_full after four", queue_full, 1);
        push_desc(32'h7700, 32'h9900, 1, 1, 0, 0, 1, 0, 0, 0);
        check("R11 still full", queue_full, 1);
        auto_sync = 1'b1;
        wait_done(13);
        cycles(50);
        check("R11 five done", done_cnt, 13);
        check("R11 no dropped beats", exp_addr.size(), 0);
        check("R11 queue drained", queue_full, 0);

        summary();
        $finish;
    end
endmodule